// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Selectable Parity

This block turns bytes into asynchronous serial frames on a single output line. A one-character holding stage sits in front of the frame shifter, so the host can queue the next character while the current one is still on the wire. Each frame is a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Every bit lasts one period of an external baud enable pulse, and frames only begin on such a pulse.

The host writes with a strobe and a data byte. It watches two flags. `tx_ready` says the holding stage can take a character. `tx_empty` says that nothing is queued and nothing is being shifted. A 3-bit mode input selects the parity bit: none, even, odd, forced low or forced high. Dropping the enable aborts any traffic and parks the line high.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, both storage stages are empty, and `tx_ready` equals `tx_en`.
- R2: `tx_ready` is 1 exactly when `tx_en` is 1 and the holding stage is empty. A write with `wr_stb` high while `tx_ready` is 1 is captured at that clock edge, and `tx_ready` is 0 in the following cycle.
- R3: A frame is a start bit of 0, then data bits 0 to 7 in that order, then the parity bit when one is enabled, then a stop bit of 1. Each bit begins at a clock edge where `baud_tick` is sampled high and holds until the next such edge. A captured character starts at the first tick edge after its capture at which the shifter is idle.
- R4: `par_mode` is sampled when a character enters the shifter. 0 = no parity bit, 1 = even (the bit makes the count of ones in data plus parity even), 2 = odd, 3 = parity bit forced 0, 4 = parity bit forced 1. Codes 5 to 7 behave as 0.
- R5: A character captured while the shifter is busy waits in the holding stage, and `tx_ready` stays 0 meanwhile. At the tick edge that ends the current stop bit, the character enters the shifter and its start bit begins with no idle bit between frames. `tx_ready` returns to 1 at that same edge.
- R6: `tx_empty` is 1 only when both stages are empty. It falls in the cycle after a write is captured, stays 0 through the whole stop bit of the last frame, and rises at the tick edge that ends that stop bit.
- R7: A write while `tx_ready` is 0 is ignored. No frame for it is ever sent, and the character already held is not altered.
- R8: A write while `tx_en` is 0 has no effect. No frame is sent for it after the block is enabled again.
- R9: While `tx_en` is 0, both stages are cleared at each clock edge. In the next cycle `txd` is 1, `tx_ready` is 0 and `tx_empty` is 1.
- R10: The line is 1 whenever `tx_empty` is 1, and `txd` changes only after a tick edge or a disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmitter enable; low clears the block |
| par_mode | input | 3 | Parity selection (0 none, 1 even, 2 odd, 3 forced 0, 4 forced 1) |
| wr_stb | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding stage can accept a character |
| tx_empty | output | 1 | Holding stage and shifter both empty |

## Verification
The bench decodes the line at every tick edge and compares each frame with a queue of accepted characters and their parity modes. This catches a wrong bit order, a wrong parity polarity, or a mode that is read at the wrong time.

Back-to-back writes check two things: that the second start bit follows the stop bit with no gap, and that `tx_ready` only rises at that handover. A design that loads early would corrupt the running frame, and one that loads late would show an idle bit. A third write that lands while the holding stage is full must never appear on the line. If it did, it would overwrite the held byte or add an extra frame. The bench also samples `tx_empty` during the last stop bit and after it, to catch a flag that rises one bit early.

Further tests cover a disable in the middle of a frame and a write made while disabled. A design that kept stale state would then send an unexpected frame once it was enabled again.

// File: rtl/utx_pkg.sv
package utx_pkg;

   typedef enum logic [2:0] {
      PAR_OFF   = 3'd0,
      PAR_EVEN  = 3'd1,
      PAR_ODD   = 3'd2,
      PAR_LOW   = 3'd3,
      PAR_HIGH  = 3'd4
   } par_sel_e;

   localparam int unsigned PAR_SEL_W = 3;

endpackage

// File: rtl/utx_parity_gen.sv
module utx_parity_gen
   import utx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic [DATA_W-1:0]    data_in,
   input  logic [PAR_SEL_W-1:0] sel_in,
   output logic                 par_bit,
   output logic                 par_on
);

   generate
      if (HAS_PARITY) begin : g_par
         logic ones_odd;
         assign ones_odd = ^data_in;

         always_comb begin
            par_on  = 1'b1;
            par_bit = 1'b0;
            case (sel_in)
               PAR_EVEN: par_bit = ones_odd;
               PAR_ODD:  par_bit = ~ones_odd;
               PAR_LOW:  par_bit = 1'b0;
               PAR_HIGH: par_bit = 1'b1;
               default:  par_on  = 1'b0;
            endcase
         end
      end else begin : g_nopar
         logic unused_in;
         assign unused_in = ^{data_in, sel_in};
         assign par_bit   = 1'b0;
         assign par_on    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/utx_hold_reg.sv
module utx_hold_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data_q,
   output logic              ready
);

   assign ready = tx_en & ~full;

   always_ff @(posedge clk) begin
      if (!rst_n || !tx_en) begin
         full   <= 1'b0;
         data_q <= '0;
      end else if (take) begin
         full   <= 1'b0;
      end else if (wr_stb && ready) begin
         full   <= 1'b1;
         data_q <= wr_data;
      end
   end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              tick,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              par_bit,
   input  logic              par_on,
   output logic              take,
   output logic              busy,
   output logic              line
);

   localparam int unsigned FRAME_W = DATA_W + 3;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LEN_PAR   = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] LEN_NOPAR = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] frame_d;
   logic [CNT_W-1:0]   left_q;
   logic [CNT_W-1:0]   len_d;
   logic               last_bit;

   assign frame_d  = par_on ? {1'b1, par_bit, hold_data, 1'b0}
                            : {1'b1, 1'b1,    hold_data, 1'b0};
   assign len_d    = par_on ? LEN_PAR : LEN_NOPAR;
   assign last_bit = busy & (left_q == ONE);
   assign take     = tx_en & tick & hold_full & (~busy | last_bit);
   assign line     = busy ? sh_q[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !tx_en) begin
         busy   <= 1'b0;
         left_q <= '0;
         sh_q   <= '1;
      end else if (tick) begin
         if (take) begin
            busy   <= 1'b1;
            left_q <= len_d;
            sh_q   <= frame_d;
         end else if (busy) begin
            if (last_bit) begin
               busy <= 1'b0;
            end
            left_q <= left_q - ONE;
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
         end
      end
   end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
   import utx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 baud_tick,
   input  logic                 tx_en,
   input  logic [PAR_SEL_W-1:0] par_mode,
   input  logic                 wr_stb,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 txd,
   output logic                 tx_ready,
   output logic                 tx_empty
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_tx_dbuf: DATA_W must lie in 5..9");
      end
   endgenerate

   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              take;
   logic              busy;
   logic              par_bit;
   logic              par_on;

   utx_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .take    (take),
      .full    (hold_full),
      .data_q  (hold_data),
      .ready   (tx_ready)
   );

   utx_parity_gen #(.DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_par (
      .data_in (hold_data),
      .sel_in  (par_mode),
      .par_bit (par_bit),
      .par_on  (par_on)
   );

   utx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .tick      (baud_tick),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .par_bit   (par_bit),
      .par_on    (par_on),
      .take      (take),
      .busy      (busy),
      .line      (txd)
   );

   assign tx_empty = ~busy & ~hold_full;

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx_en,
   input logic wr_stb,
   input logic txd,
   input logic tx_ready,
   input logic tx_empty
);

   // R2
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && wr_stb) |=> !tx_ready);

   // R6
   empty_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && wr_stb) |=> !tx_empty);

   // R9
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (txd && tx_empty));

   // R10
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> txd);

   // R3
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !baud_tick) |=> $stable(txd));

   // R9
   ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !tx_ready);

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .baud_tick (baud_tick),
   .tx_en     (tx_en),
   .wr_stb    (wr_stb),
   .txd       (txd),
   .tx_ready  (tx_ready),
   .tx_empty  (tx_empty)
);

// File: tb/uart_tx_dbuf_tb_top.sv
module uart_tx_dbuf_tb_top;

   localparam int TDIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       tx_en = 1'b0;
   logic [2:0] par_mode = 3'd0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd;
   logic       tx_ready;
   logic       tx_empty;

   int checks = 0;
   int errors = 0;
   int frames = 0;
   bit last_acc;

   typedef struct packed {
      logic [7:0] d;
      logic [2:0] m;
      logic       b2b;
   } exp_t;

   exp_t q[$];

   uart_tx_dbuf dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .tx_en     (tx_en),
      .par_mode  (par_mode),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .txd       (txd),
      .tx_ready  (tx_ready),
      .tx_empty  (tx_empty)
   );

   always #5 clk = ~clk;

   int tcnt = 0;
   always @(posedge clk) begin
      #1;
      if (tcnt == TDIV - 1) begin
         tcnt = 0;
         baud_tick = 1'b1;
      end else begin
         tcnt++;
         baud_tick = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   function automatic bit par_used(input logic [2:0] m);
      return (m >= 3'd1) && (m <= 3'd4);
   endfunction

   function automatic logic exp_par(input logic [2:0] m, input logic [7:0] d);
      case (m)
         3'd1:    return ^d;
         3'd2:    return ~(^d);
         3'd3:    return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   // Line monitor: decodes one bit at each tick edge.
   bit          prev_tick = 0;
   bit          active = 0;
   bit          after_stop = 0;
   int          idx = 0;
   int          flen = 0;
   logic [10:0] bits;
   always @(negedge clk) begin
      bit boundary;
      boundary  = prev_tick;
      prev_tick = baud_tick;
      if (!tx_en || !rst_n) begin
         active     = 0;
         after_stop = 0;
      end else if (boundary) begin
         if (!active) begin
            if (after_stop) begin
               after_stop = 0;
               if (q.size() == 0) begin
                  chk(tx_empty == 1'b1, "R6 empty after stop", int'(tx_empty), 1);
               end else if (q[0].b2b) begin
                  chk(txd == 1'b0, "R5 no idle gap", int'(txd), 0);
                  chk(tx_ready == 1'b1, "R5 ready at handover", int'(tx_ready), 1);
               end
            end
            if (txd == 1'b0) begin
               if (q.size() == 0) begin
                  chk(0, "R7 unexpected frame", 1, 0);
               end else begin
                  active  = 1;
                  idx     = 1;
                  bits    = '1;
                  bits[0] = 1'b0;
                  flen    = par_used(q[0].m) ? 11 : 10;
               end
            end
         end else begin
            bits[idx] = txd;
            idx++;
            if (idx == flen) begin
               exp_t e;
               e = q.pop_front();
               frames++;
               active     = 0;
               after_stop = 1;
               chk(bits[8:1] == e.d, "R3 data bits", int'(bits[8:1]), int'(e.d));
               if (par_used(e.m))
                  chk(bits[9] == exp_par(e.m, e.d), "R4 parity bit",
                      int'(bits[9]), int'(exp_par(e.m, e.d)));
               chk(bits[flen-1] == 1'b1, "R3 stop bit", int'(bits[flen-1]), 1);
               chk(tx_empty == 1'b0, "R6 empty low in stop", int'(tx_empty), 0);
            end
         end
      end
   end

   task automatic send(input logic [7:0] d);
      exp_t e;
      @(posedge clk); #2;
      wr_stb  = 1'b1;
      wr_data = d;
      @(negedge clk);
      if (tx_ready) begin
         e.d   = d;
         e.m   = par_mode;
         e.b2b = !tx_empty && !baud_tick;
         q.push_back(e);
         last_acc = 1;
      end else begin
         last_acc = 0;
      end
      @(posedge clk); #2;
      wr_stb = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (tx_empty && q.size() == 0 && !active) break;
      end
      repeat (2 * TDIV) @(posedge clk);
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (tx_ready) break;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
      chk(tx_empty == 1'b1, "R1 empty", int'(tx_empty), 1);
      chk(tx_ready == 1'b0, "R1 ready follows enable", int'(tx_ready), 0);
      @(posedge clk); #2;
      rst_n = 1'b1;

      // R8 write while disabled
      par_mode = 3'd1;
      send(8'hA5);
      chk(last_acc == 0, "R8 disabled write refused", int'(last_acc), 0);
      @(posedge clk); #2;
      tx_en = 1'b1;
      repeat (15 * TDIV) @(posedge clk);
      @(negedge clk);
      chk(tx_empty == 1'b1, "R8 nothing pending", int'(tx_empty), 1);
      chk(tx_ready == 1'b1, "R2 ready once enabled", int'(tx_ready), 1);
      chk(frames == 0, "R8 no frame sent", frames, 0);

      // R2 / R6 single write
      send(8'h5A);
      @(negedge clk);
      chk(tx_ready == 1'b0, "R2 ready after capture", int'(tx_ready), 0);
      chk(tx_empty == 1'b0, "R6 empty after capture", int'(tx_empty), 0);
      wait_idle();

      // R5 / R7 back-to-back with a refused third write
      send(8'hC3);
      wait_ready();
      send(8'h3C);
      chk(last_acc == 1, "R5 second write taken", int'(last_acc), 1);
      send(8'hFF);
      chk(last_acc == 0, "R7 third write refused", int'(last_acc), 0);
      repeat (TDIV) @(posedge clk);
      @(negedge clk);
      chk(tx_ready == 1'b0, "R5 ready held low", int'(tx_ready), 0);
      wait_idle();

      // R4 every parity code, including unused codes
      for (int m = 0; m < 8; m++) begin
         par_mode = 3'(m);
         send(8'h00);
         wait_ready();
         send(8'hFF);
         wait_ready();
         send(8'h6B);
         wait_idle();
      end

      // R9 disable during a frame with a held character
      par_mode = 3'd2;
      send(8'h81);
      wait_ready();
      send(8'h42);
      repeat (3 * TDIV) @(posedge clk);
      #2;
      tx_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(txd == 1'b1, "R9 line idle", int'(txd), 1);
      chk(tx_ready == 1'b0, "R9 ready low", int'(tx_ready), 0);
      chk(tx_empty == 1'b1, "R9 empty", int'(tx_empty), 1);
      q.delete();
      @(posedge clk); #2;
      tx_en = 1'b1;
      repeat (15 * TDIV) @(posedge clk);
      @(negedge clk);
      chk(tx_empty == 1'b1, "R9 nothing resumes", int'(tx_empty), 1);

      // Random traffic
      for (int n = 0; n < 80; n++) begin
         repeat ($urandom_range(0, 40)) @(posedge clk);
         if (tx_empty && q.size() == 0 && $urandom_range(0, 3) == 0)
            par_mode = 3'($urandom_range(0, 7));
         send(8'($urandom));
      end
      wait_idle();
      chk(q.size() == 0, "R3 all frames delivered", q.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule